// File: doc/BRIEF.md
# Pipelined Tag Match Memory

A synchronous tag store for a cache controller. Each entry is an 18-bit word organised as two 9-bit lanes. Address, chip selects and write controls are captured at every rising clock edge. A separate input register captures the data bus only when its load strobe is low and the block is selected. On every selected cycle, the word at the captured address is compared against the input register. The equality result goes through a pipeline flop and appears on the hit output one clock later.

Writes always take their data from the input register. A normal write loads the register from the bus and then stores it. A "fill" write keeps the register unchanged, with the bus left undriven, and stores the value the register already holds. This lets a controller write back the tag it just compared without driving the bus again.

Read data and the hit flag each have an asynchronous output enable. A disabled output is modelled as a low valid flag together with an all-Z value. The array depth is a parameter.

Top module: `tag_match_ram`

## Requirements
- R1: The block is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. In any other case nothing is written. After a deselected cycle, `hit` is 1 one clock later while `hit_oe_n` is low.
- R2: The input register loads `d_in` only in a cycle with `din_ld_n`=0 and the block selected. Otherwise it keeps its value.
- R3: A write takes place when `byte_wr_n`=0 and at least one lane strobe is low. `wr_lo_n`=0 writes bits [8:0] and `wr_hi_n`=0 writes bits [17:9]. With `byte_wr_n`=1 the lane strobes have no effect.
- R4: `wr_all_n`=0 writes all 18 bits, whatever the values of `byte_wr_n`, `wr_lo_n` and `wr_hi_n`.
- R5: A compare is a selected cycle. Its inputs (address and data) are presented before edge N. `hit` shows equality between the input register and the stored word after edge N+1, and successive compares pipeline one per clock.
- R6: `hit` is 0 when the input register and the stored word differ.
- R7: A write cycle with `din_ld_n`=1 (fill write) stores the value already held in the input register and ignores `d_in`.
- R8: A selected non-write cycle presented before edge N puts the stored word on `q_out` after edge N+1, with `q_valid`=1 when `q_oe_n`=0.
- R9: `q_oe_n`=1 forces `q_valid`=0 and `q_out` to all Z. `hit_oe_n`=1 forces `hit_valid`=0 and `hit` to Z. Both take effect without a clock edge.
- R10: A write and a compare to the same address in the same cycle compare against the word as it was before the write.
- R11: After synchronous reset, `hit` is 1 and `q_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| sel_a_n | input | 1 | Select, active low |
| sel_b_n | input | 1 | Select, active low |
| sel_c | input | 1 | Select, active high |
| wr_lo_n | input | 1 | Low lane write strobe, bits [8:0] |
| wr_hi_n | input | 1 | High lane write strobe, bits [17:9] |
| byte_wr_n | input | 1 | Gate for the lane strobes, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| din_ld_n | input | 1 | Input register load strobe, active low |
| d_in | input | 2*LANE_W | Data bus, input side |
| q_out | output | 2*LANE_W | Read data, Z when disabled |
| q_valid | output | 1 | Read data valid |
| q_oe_n | input | 1 | Read data output enable, asynchronous, active low |
| hit_oe_n | input | 1 | Hit output enable, asynchronous, active low |
| hit | output | 1 | Pipelined match flag, Z when disabled |
| hit_valid | output | 1 | Hit flag valid |

## Verification
A compare and a write of the same address can occur in one cycle, because every selected cycle compares, including write cycles. The bench provokes this in two ways. First, it writes a word that differs from the stored word, and expects `hit` low, since the compare must see the old contents. Second, it rewrites the same value, and expects `hit` high. A following read confirms what was actually stored. Fill writes are exercised the same way: a garbage bus value is presented alongside the fill write, and the readback must show the earlier compared value.

// File: rtl/tmr_pkg.sv
// Package: shared cycle descriptor for the tag match memory.
// Assumes exactly two data lanes, one per lane write strobe.
package tmr_pkg;
    localparam int NLANE = 2;

    // Registered description of one bus cycle
    typedef struct packed {
        logic             sel;  // block was selected
        logic             rd;   // selected and not a write
        logic [NLANE-1:0] we;   // per-lane write enables
    } cyc_t;
endpackage

// File: rtl/tmr_ctrl.sv
// Module: tmr_ctrl
// Decodes the select and write inputs and registers them with the address.
// Assumes all inputs are synchronous to clk. Reset is synchronous, active low.
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              wr_lo_n,
    input  logic              wr_hi_n,
    input  logic              byte_wr_n,
    input  logic              wr_all_n,
    input  logic              din_ld_n,
    output logic              din_load,
    output cyc_t              cyc_q,
    output logic [ADDR_W-1:0] addr_q
);
    logic             sel;
    logic             wq_n;
    logic [NLANE-1:0] lane_en;

    // Decode the selection, the write qualifier and the lane enables
    always_comb begin
        sel        = ~sel_a_n & ~sel_b_n & sel_c;
        wq_n       = (byte_wr_n | (wr_lo_n & wr_hi_n)) & wr_all_n;
        lane_en[0] = ~wr_all_n | (~byte_wr_n & ~wr_lo_n);
        lane_en[1] = ~wr_all_n | (~byte_wr_n & ~wr_hi_n);
        din_load   = sel & ~din_ld_n;
    end

    // Register the cycle descriptor and the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            addr_q <= '0;
        end else begin
            cyc_q.sel <= sel;
            cyc_q.rd  <= sel & wq_n;
            cyc_q.we  <= (sel & ~wq_n) ? lane_en : '0;
            addr_q    <= addr;
        end
    end

    // R1
    sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_n || sel_b_n || !sel_c) |=> (!cyc_q.sel && cyc_q.we == '0));

    // R4
    all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && !sel_b_n && sel_c && !wr_all_n) |=> (cyc_q.we == 2'b11 && !cyc_q.rd));

    // R3
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr_n && wr_all_n) |=> (cyc_q.we == '0));
endmodule

// File: rtl/tmr_din_reg.sv
// Module: tmr_din_reg
// Holds the value that is compared and written; loads only on request.
// Assumes load is already qualified by selection. Reset is synchronous, active low.
module tmr_din_reg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] held
);
    // Capture the bus on a load, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= d;
    end

    // R2
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));

    // R2
    din_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (held == $past(d)));
endmodule

// File: rtl/tmr_array.sv
// Module: tmr_array
// Storage split into independent lanes, each with its own write enable.
// The read is combinational from the registered address. Contents are not reset.
module tmr_array
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NLANE-1:0]        we,
    input  logic [NLANE*LANE_W-1:0] wdata,
    output logic [NLANE*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Write one lane at the clock edge when enabled
        always_ff @(posedge clk) begin
            if (we[l]) store[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        // Present the lane's word at the registered address
        assign rdata[l*LANE_W +: LANE_W] = store[addr];
    end
endmodule

// File: rtl/tmr_out_pipe.sv
// Module: tmr_out_pipe
// Compares the input register with the stored word and registers the result.
// Also registers read data. A deselected cycle yields a high match flag.
module tmr_out_pipe #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_q,
    input  logic         rd_q,
    input  logic [W-1:0] held,
    input  logic [W-1:0] word,
    output logic         match_q,
    output logic         q_ok,
    output logic [W-1:0] q_word
);
    // Register the compare result and the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b1;
            q_ok    <= 1'b0;
            q_word  <= '0;
        end else begin
            match_q <= sel_q ? (held == word) : 1'b1;
            q_ok    <= rd_q;
            if (rd_q) q_word <= word;
        end
    end

    // R1
    desel_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |=> match_q);

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> (q_ok && q_word == $past(word)));
endmodule

// File: rtl/tag_match_ram.sv
// Module: tag_match_ram
// Tag memory with a registered compare. Writes always take data from the
// input register, so a write with the load strobe high stores the held value.
// Assumes synchronous inputs except the two output enables.
module tag_match_ram
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    wr_lo_n,
    input  logic                    wr_hi_n,
    input  logic                    byte_wr_n,
    input  logic                    wr_all_n,
    input  logic                    din_ld_n,
    input  logic [NLANE*LANE_W-1:0] d_in,
    output logic [NLANE*LANE_W-1:0] q_out,
    output logic                    q_valid,
    input  logic                    q_oe_n,
    input  logic                    hit_oe_n,
    output logic                    hit,
    output logic                    hit_valid
);
    localparam int W = NLANE * LANE_W;

    cyc_t              cyc_q;
    logic [ADDR_W-1:0] addr_q;
    logic              din_load;
    logic [W-1:0]      held;
    logic [W-1:0]      word;
    logic              match_q;
    logic              q_ok;
    logic [W-1:0]      q_word;

    tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .byte_wr_n(byte_wr_n),
        .wr_all_n(wr_all_n), .din_ld_n(din_ld_n),
        .din_load(din_load), .cyc_q(cyc_q), .addr_q(addr_q)
    );

    tmr_din_reg #(.W(W)) u_din (
        .clk(clk), .rst_n(rst_n), .load(din_load), .d(d_in), .held(held)
    );

    tmr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk(clk), .addr(addr_q), .we(cyc_q.we), .wdata(held), .rdata(word)
    );

    tmr_out_pipe #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .sel_q(cyc_q.sel), .rd_q(cyc_q.rd),
        .held(held), .word(word),
        .match_q(match_q), .q_ok(q_ok), .q_word(q_word)
    );

    // Asynchronous output gating of read data and hit flag
    always_comb begin
        q_valid   = ~q_oe_n & q_ok;
        q_out     = q_valid ? q_word : {W{1'bz}};
        hit_valid = ~hit_oe_n;
        hit       = hit_oe_n ? 1'bz : match_q;
    end
endmodule

// File: tb/test_tag_match_ram.sv
// Directed bench for tag_match_ram. Inputs change at the falling edge; results
// are sampled at the falling edge that follows the edge producing them.
module test_tag_match_ram;
    localparam int AW = 4;
    localparam int W  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
    logic wr_lo_n = 1'b1, wr_hi_n = 1'b1, byte_wr_n = 1'b1, wr_all_n = 1'b1;
    logic din_ld_n = 1'b1;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_out;
    logic q_valid, hit, hit_valid;
    logic q_oe_n = 1'b0, hit_oe_n = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tag_match_ram #(.ADDR_W(AW), .LANE_W(9)) i_tag_match_ram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .byte_wr_n(byte_wr_n),
        .wr_all_n(wr_all_n), .din_ld_n(din_ld_n), .d_in(d_in),
        .q_out(q_out), .q_valid(q_valid), .q_oe_n(q_oe_n),
        .hit_oe_n(hit_oe_n), .hit(hit), .hit_valid(hit_valid)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One cycle of stimulus, then wait for the next falling edge
    task automatic drive(input logic [AW-1:0] a, input logic sa, input logic sb, input logic sc,
                         input logic gw, input logic bw, input logic wl, input logic wh,
                         input logic dl, input logic [W-1:0] d);
        addr = a; sel_a_n = sa; sel_b_n = sb; sel_c = sc;
        wr_all_n = gw; byte_wr_n = bw; wr_lo_n = wl; wr_hi_n = wh;
        din_ld_n = dl; d_in = d;
        @(negedge clk);
    endtask

    task automatic idle();
        drive('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0);
    endtask

    task automatic wr_full(input logic [AW-1:0] a, input logic [W-1:0] d);
        drive(a, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, d);
    endtask

    task automatic cmp_cycle(input logic [AW-1:0] a, input logic [W-1:0] d);
        drive(a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, d);
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
        drive(a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        idle();
        chk({req, " q_valid"}, W'(q_valid), W'(1));
        chk({req, " q_out"}, q_out, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 hit after reset", W'(hit), W'(1));
        chk("R11 q_valid after reset", W'(q_valid), W'(0));
    endtask

    task automatic t_write_read();
        wr_full(4'd3, 18'h2A5A5);
        wr_full(4'd4, 18'h15A5A);
        idle();
        read_chk("R8 addr3", 4'd3, 18'h2A5A5);
        read_chk("R8 addr4", 4'd4, 18'h15A5A);
    endtask

    task automatic t_compare();
        cmp_cycle(4'd3, 18'h2A5A5);
        idle();
        chk("R5 equal word", W'(hit), W'(1));
        cmp_cycle(4'd3, 18'h2A5A4);
        idle();
        chk("R6 single-bit difference", W'(hit), W'(0));
        // back-to-back compares: mismatch then match
        cmp_cycle(4'd4, 18'h00000);
        cmp_cycle(4'd4, 18'h15A5A);
        chk("R5 pipelined first", W'(hit), W'(0));
        idle();
        chk("R5 pipelined second", W'(hit), W'(1));
    endtask

    task automatic t_din_hold();
        cmp_cycle(4'd3, 18'h2A5A5);
        // load strobe high: bus value must not reach the register
        drive(4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 18'h00000);
        idle();
        chk("R2 strobe high keeps value", W'(hit), W'(1));
        // deselected with strobe low: no load either
        drive(4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h00000);
        drive(4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 18'h00000);
        idle();
        chk("R2 deselected keeps value", W'(hit), W'(1));
    endtask

    task automatic t_fill();
        wr_full(4'd5, 18'h00000);
        cmp_cycle(4'd5, 18'h3C3C3);
        // fill write: strobe high, garbage on the bus
        drive(4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h12345);
        idle();
        read_chk("R7 fill write", 4'd5, 18'h3C3C3);
    endtask

    task automatic t_lanes();
        wr_full(4'd6, {9'h0AA, 9'h155});
        drive(4'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, {9'h1FF, 9'h0C3});
        idle();
        read_chk("R3 low lane only", 4'd6, {9'h0AA, 9'h0C3});
        drive(4'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {9'h111, 9'h000});
        idle();
        read_chk("R3 high lane only", 4'd6, {9'h111, 9'h0C3});
        drive(4'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00000);
        idle();
        read_chk("R3 strobes without gate", 4'd6, {9'h111, 9'h0C3});
        // whole-word write overrides lane strobes that select one lane
        drive(4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h24924);
        idle();
        read_chk("R4 whole word over lane strobes", 4'd6, 18'h24924);
    endtask

    task automatic t_select();
        wr_full(4'd7, 18'h0F0F0);
        drive(4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF);
        drive(4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF);
        drive(4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF);
        idle();
        read_chk("R1 no write when deselected", 4'd7, 18'h0F0F0);
        cmp_cycle(4'd7, 18'h00001);
        drive(4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        chk("R1 mismatch before deselect", W'(hit), W'(0));
        idle();
        chk("R1 hit forced high when deselected", W'(hit), W'(1));
    endtask

    task automatic t_same_cycle();
        wr_full(4'd8, 18'h00111);
        wr_full(4'd8, 18'h00222);
        idle();
        chk("R10 compare sees old word", W'(hit), W'(0));
        wr_full(4'd8, 18'h00222);
        idle();
        chk("R10 rewrite same value", W'(hit), W'(1));
        read_chk("R10 stored value", 4'd8, 18'h00222);
    endtask

    task automatic t_out_enables();
        read_chk("R9 setup read", 4'd3, 18'h2A5A5);
        q_oe_n = 1'b1;
        #1;
        chk("R9 q_valid off", W'(q_valid), W'(0));
        chk("R9 q_out Z", q_out, {W{1'bz}});
        q_oe_n = 1'b0;
        #1;
        chk("R9 q_out back", q_out, 18'h2A5A5);
        hit_oe_n = 1'b1;
        #1;
        chk("R9 hit_valid off", W'(hit_valid), W'(0));
        chk("R9 hit Z", {{(W-1){1'b0}}, hit}, {{(W-1){1'b0}}, 1'bz});
        hit_oe_n = 1'b0;
        #1;
        chk("R9 hit_valid on", W'(hit_valid), W'(1));
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_read();
        t_compare();
        t_din_hold();
        t_fill();
        t_lanes();
        t_select();
        t_same_cycle();
        t_out_enables();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule